// File: doc/BRIEF.md
# Contactless Card Poll Responder

This block is the answering side of a simple contactless card. A frame receiver, outside the block, assembles each incoming frame and then reports three things: that the frame is complete, whether its CRC was good, and the frame's length, command and request-code bytes. The receiver also reports the time at which the frame's last byte arrived. The responder decides whether the frame calls for an answer and picks one of three fixed reply templates. It latches the card's 8-byte identifier into that reply, waits out a fixed turnaround measured from the last received byte, and then streams the reply to a frame transmitter.

Frames are handled as follows. A frame with a bad CRC is dropped. A frame with a command the block does not know is also dropped. In every case the receiver is told to clear itself, so it can take the next frame.

The reply leaves the block on a valid/ready byte stream. A byte is transferred on each clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the block holds `tx_data` and `tx_last` unchanged. The stream carries the reply from the two sync bytes up to the end of the payload. The transmitter appends the two CRC bytes that follow, computing them over the patched bytes. Time is supplied on `now_ts` as a free-running tick count that wraps modulo 2^16.

Top module: `card_poll_responder`

## Requirements
- R1: A completed frame whose CRC flag is low produces no reply. `rx_clear` is high for one cycle on the clock edge after `rx_done` is seen.
- R2: A good frame with length byte 6, command 0x00 and request code 0 gets the basic poll reply. This is a stream of 20 bytes: B2 4D 12 01, then the identifier, then 00 F1 00 00 00 01 43 00.
- R3: A good frame with length byte 6, command 0x00 and request code 1 gets the system-code poll reply. This is a stream of 22 bytes: B2 4D 14 01, then the identifier, then 00 F1 00 00 00 01 43 00 88 B4.
- R4: A good frame with a length byte above 5 and command 0x06 gets the read reply. This is a stream of 31 bytes: B2 4D 1D 07, then the identifier, then 00 00 01 10 04 01 00 0D 00 00 00 00 00 01 00 00 00 00 23.
- R5: Any other good frame produces no reply and still pulses `rx_clear`. This covers other commands, a poll whose length is not 6, a poll whose request code is 2 or more, and a read whose length is 5 or less.
- R6: Stream bytes 4 to 11 carry `card_id`, with `card_id[63:56]` first. The identifier is captured when the frame is accepted, so later changes on `card_id` do not alter a pending reply.
- R7: `tx_last` is high on the final payload byte of the stream and on no other byte. The CRC bytes are not part of the stream.
- R8: `tx_valid` first rises one cycle after `now_ts - rx_last_ts` (mod 2^16) reaches 512. If 512 ticks have already passed when the frame is accepted, it rises two cycles after acceptance.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold. The stream advances only on a transfer.
- R10: One cycle after the final transfer, `rx_clear` pulses and `tx_valid` is low, and the block listens again. An `rx_done` that arrives while a reply is pending or being sent is ignored and causes neither a clear nor a second reply.
- R11: During and just after reset, `tx_valid` and `rx_clear` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_id | input | 64 | Card identifier, first byte in bits 63:56 |
| rx_done | input | 1 | Receiver reports a complete frame |
| rx_crc_ok | input | 1 | Received frame's CRC matched |
| rx_len | input | 8 | Length byte of received frame |
| rx_cmd | input | 8 | Command byte of received frame |
| rx_req | input | 8 | Request-code byte (frame index 6) |
| rx_last_ts | input | 16 | Tick time of the frame's last byte |
| now_ts | input | 16 | Current tick time |
| rx_clear | output | 1 | One-cycle request to clear the receiver |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Final byte before CRC |

## Verification
The bench targets the classification edges:
- A poll of length 7 or with request code 2, or a read of length exactly 5. A decoder that is off by one would answer these with a reply stream.
- Frames whose last byte lies far in the past, and timestamps that straddle the 16-bit wrap. A turnaround computed without modular subtraction would start the reply hundreds of cycles late or early, and the first-byte timing check compares the exact tick.
- Heavy back-pressure, to expose a byte index that advances without a transfer.
- A change on `card_id` right after acceptance, to expose a design that reads the live identifier.
- A stray `rx_done` while a reply is waiting. A design that handles it would emit an extra clear or a second reply.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  typedef enum logic [1:0] {
    RK_NONE     = 2'd0,
    RK_POLL     = 2'd1,
    RK_POLL_SYS = 2'd2,
    RK_READ     = 2'd3
  } reply_kind_t;

  localparam int IDX_W = 5;

  localparam logic [7:0] CMD_POLL     = 8'h00;
  localparam logic [7:0] CMD_READ     = 8'h06;
  localparam logic [7:0] POLL_LEN     = 8'd6;
  localparam logic [7:0] READ_MIN_LEN = 8'd6;

  // number of streamed bytes (sync through payload, CRC excluded)
  function automatic logic [IDX_W-1:0] reply_len(reply_kind_t k);
    case (k)
      RK_POLL:     reply_len = 5'd20;
      RK_POLL_SYS: reply_len = 5'd22;
      RK_READ:     reply_len = 5'd31;
      default:     reply_len = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/cpr_classify.sv
module cpr_classify
  import cpr_pkg::*;
(
  input  logic [7:0]  len_byte,
  input  logic [7:0]  cmd_byte,
  input  logic [7:0]  req_byte,
  output reply_kind_t kind
);
  logic is_poll, is_read;

  always_comb begin
    is_poll = (cmd_byte == CMD_POLL) && (len_byte == POLL_LEN);
    is_read = (cmd_byte == CMD_READ) && (len_byte >= READ_MIN_LEN);
    kind    = RK_NONE;
    if (is_poll && req_byte == 8'd0)      kind = RK_POLL;
    else if (is_poll && req_byte == 8'd1) kind = RK_POLL_SYS;
    else if (is_read)                     kind = RK_READ;
  end
endmodule

// File: rtl/cpr_gap_timer.sv
module cpr_gap_timer #(
  parameter int TS_W      = 16,
  parameter int GAP_TICKS = 512
) (
  input  logic [TS_W-1:0] now_ts,
  input  logic [TS_W-1:0] base_ts,
  output logic            met
);
  localparam logic [TS_W-1:0] GAP_V = TS_W'(GAP_TICKS);

  logic [TS_W-1:0] elapsed;

  always_comb begin
    elapsed = now_ts - base_ts;   // wraps modulo 2^TS_W
    met     = (elapsed >= GAP_V);
  end
endmodule

// File: rtl/cpr_reply_rom.sv
module cpr_reply_rom
  import cpr_pkg::*;
(
  input  reply_kind_t      kind,
  input  logic [IDX_W-1:0] idx,
  input  logic [63:0]      card_id,
  output logic [7:0]       data
);
  logic [2:0] id_pos;
  logic [7:0] id_byte, poll_tail, read_tail;

  always_comb begin
    id_pos  = 3'(idx - 5'd4);
    id_byte = card_id[{3'd7 - id_pos, 3'b000} +: 8];
  end

  // payload after identifier, poll variants (bytes 12..21)
  always_comb begin
    case (idx)
      5'd13:   poll_tail = 8'hF1;
      5'd17:   poll_tail = 8'h01;
      5'd18:   poll_tail = 8'h43;
      5'd20:   poll_tail = 8'h88;
      5'd21:   poll_tail = 8'hB4;
      default: poll_tail = 8'h00;
    endcase
  end

  // payload after identifier, read variant (bytes 12..30)
  always_comb begin
    case (idx)
      5'd14:   read_tail = 8'h01;
      5'd15:   read_tail = 8'h10;
      5'd16:   read_tail = 8'h04;
      5'd17:   read_tail = 8'h01;
      5'd19:   read_tail = 8'h0D;
      5'd25:   read_tail = 8'h01;
      5'd30:   read_tail = 8'h23;
      default: read_tail = 8'h00;
    endcase
  end

  always_comb begin
    data = 8'h00;
    if (idx == 5'd0)      data = 8'hB2;
    else if (idx == 5'd1) data = 8'h4D;
    else if (idx == 5'd2) data = 8'(reply_len(kind) - 5'd2);
    else if (idx == 5'd3) data = (kind == RK_READ) ? 8'h07 : 8'h01;
    else if (idx <= 5'd11) data = id_byte;
    else if (idx < reply_len(kind))
      data = (kind == RK_READ) ? read_tail : poll_tail;
  end
endmodule

// File: rtl/card_poll_responder.sv
module card_poll_responder
  import cpr_pkg::*;
#(
  parameter int TS_W      = 16,
  parameter int GAP_TICKS = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [63:0]     card_id,
  input  logic            rx_done,
  input  logic            rx_crc_ok,
  input  logic [7:0]      rx_len,
  input  logic [7:0]      rx_cmd,
  input  logic [7:0]      rx_req,
  input  logic [TS_W-1:0] rx_last_ts,
  input  logic [TS_W-1:0] now_ts,
  output logic            rx_clear,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [7:0]      tx_data,
  output logic            tx_last
);
  typedef enum logic [1:0] {ST_LISTEN, ST_WAIT, ST_SEND} st_t;

  st_t              st;
  reply_kind_t      rx_kind, kind_q;
  logic [63:0]      id_q;
  logic [TS_W-1:0]  ts_q;
  logic [IDX_W-1:0] idx_q, last_idx;
  logic             gap_met, clr_q;

  cpr_classify u_cls (
    .len_byte (rx_len),
    .cmd_byte (rx_cmd),
    .req_byte (rx_req),
    .kind     (rx_kind)
  );

  cpr_gap_timer #(.TS_W(TS_W), .GAP_TICKS(GAP_TICKS)) u_gap (
    .now_ts  (now_ts),
    .base_ts (ts_q),
    .met     (gap_met)
  );

  cpr_reply_rom u_rom (
    .kind    (kind_q),
    .idx     (idx_q),
    .card_id (id_q),
    .data    (tx_data)
  );

  always_comb begin
    last_idx = reply_len(kind_q) - 5'd1;
    tx_valid = (st == ST_SEND);
    tx_last  = tx_valid && (idx_q == last_idx);
    rx_clear = clr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_LISTEN;
      kind_q <= RK_NONE;
      id_q   <= '0;
      ts_q   <= '0;
      idx_q  <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      case (st)
        ST_LISTEN: if (rx_done) begin
          clr_q <= 1'b1;
          if (rx_crc_ok && rx_kind != RK_NONE) begin
            kind_q <= rx_kind;
            id_q   <= card_id;
            ts_q   <= rx_last_ts;
            st     <= ST_WAIT;
          end
        end
        ST_WAIT: if (gap_met) begin
          idx_q <= '0;
          st    <= ST_SEND;
        end
        ST_SEND: if (tx_ready) begin
          if (idx_q == last_idx) begin
            clr_q <= 1'b1;
            st    <= ST_LISTEN;
          end else begin
            idx_q <= idx_q + 5'd1;
          end
        end
        default: st <= ST_LISTEN;
      endcase
    end
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R1
  clear_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LISTEN) && rx_done |=> rx_clear);

  // R1
  bad_crc_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LISTEN) && rx_done && !rx_crc_ok |=> st == ST_LISTEN);

  // R10
  clear_after_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> rx_clear && !tx_valid);

  // R8
  gap_before_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(gap_met));
endmodule

// File: tb/sim_card_poll_responder.sv
module sim_card_poll_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] card_id = '0;
  logic        rx_done = 1'b0, rx_crc_ok = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_len = '0, rx_cmd = '0, rx_req = '0;
  logic [15:0] rx_last_ts = '0, now_ts = '0;
  logic        rx_clear, tx_valid, tx_last;
  logic [7:0]  tx_data;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  card_poll_responder u0 (
    .clk(clk), .rst_n(rst_n), .card_id(card_id), .rx_done(rx_done),
    .rx_crc_ok(rx_crc_ok), .rx_len(rx_len), .rx_cmd(rx_cmd), .rx_req(rx_req),
    .rx_last_ts(rx_last_ts), .now_ts(now_ts), .rx_clear(rx_clear),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    now_ts = now_ts + 16'd1;
  endtask

  // 0 none, 1 poll, 2 poll with system code, 3 read
  function automatic int exp_kind(bit [7:0] l, bit [7:0] c, bit [7:0] r, bit crc);
    if (!crc) return 0;
    if (c == 8'h00 && l == 8'd6 && r == 8'd0) return 1;
    if (c == 8'h00 && l == 8'd6 && r == 8'd1) return 2;
    if (c == 8'h06 && l > 8'd5) return 3;
    return 0;
  endfunction

  function automatic int exp_count(int k);
    return (k == 1) ? 20 : (k == 2) ? 22 : 31;
  endfunction

  function automatic bit [7:0] exp_byte(int k, int i, bit [63:0] id);
    bit [7:0] pt [10] = '{8'h00, 8'hF1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h43, 8'h00, 8'h88, 8'hB4};
    bit [7:0] rt [19] = '{8'h00, 8'h00, 8'h01, 8'h10, 8'h04, 8'h01, 8'h00, 8'h0D, 8'h00, 8'h00,
                          8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h23};
    if (i == 0) return 8'hB2;
    if (i == 1) return 8'h4D;
    if (i == 2) return (k == 1) ? 8'h12 : (k == 2) ? 8'h14 : 8'h1D;
    if (i == 3) return (k == 3) ? 8'h07 : 8'h01;
    if (i < 12) return id[63 - 8*(i-4) -: 8];
    return (k == 3) ? rt[i-12] : pt[i-12];
  endfunction

  function automatic string rtag(int k);
    return (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
  endfunction

  task automatic frame(input bit [7:0] l, input bit [7:0] c, input bit [7:0] r, input bit crc,
                       input int off, input int rdy_pct, input bit stray);
    bit [63:0] id = {$urandom(), $urandom()};
    int k = exp_kind(l, c, r, crc);
    bit [15:0] lts;
    int got = 0, cyc = 0, el_exp;
    bit first = 1, stalled = 0, seen = 0, done = 0;
    bit [7:0] held = 0;
    bit [7:0] eb;
    step();
    card_id = id; rx_done = 1; rx_crc_ok = crc; rx_len = l; rx_cmd = c; rx_req = r;
    lts = now_ts - 16'(off);
    rx_last_ts = lts;
    step();
    rx_done = 0;
    card_id = ~id;  // R6: pending reply must keep the captured identifier
    chk(rx_clear === 1'b1, crc ? (k == 0 ? "R5 clear" : "R10 clear on accept") : "R1 clear",
        rx_clear, 1);
    if (k == 0) begin
      repeat (600) begin step(); if (tx_valid) seen = 1; end
      chk(!seen, crc ? "R5 no reply" : "R1 no reply", seen, 0);
      return;
    end
    el_exp = (off + 2 > 513) ? off + 2 : 513;
    while (!done && cyc < 4000) begin
      step();
      cyc++;
      if (stray && cyc == 3) begin
        rx_done = 1; rx_crc_ok = 1; rx_len = 8'd6; rx_cmd = 8'h00; rx_req = 8'd0;
      end else if (stray && cyc == 4) begin
        rx_done = 0;
        chk(rx_clear === 1'b0, "R10 stray ignored", rx_clear, 0);
      end
      if (tx_valid) begin
        if (first) begin
          chk(int'(16'(now_ts - lts)) == el_exp, "R8 turnaround", 16'(now_ts - lts), el_exp);
          first = 0;
        end
        if (stalled) chk(tx_data == held, "R9 hold", tx_data, held);
        tx_ready = (($urandom() % 100) < rdy_pct);
        if (tx_ready) begin
          eb = exp_byte(k, got, id);
          chk(tx_data == eb, (got >= 4 && got < 12) ? "R6 id byte" : rtag(k), tx_data, eb);
          chk(tx_last == (got == exp_count(k) - 1), "R7 last flag", tx_last, got == exp_count(k) - 1);
          got++;
          if (tx_last) done = 1;
        end
        stalled = !tx_ready; held = tx_data;
      end
    end
    chk(got == exp_count(k), rtag(k), got, exp_count(k));
    step();
    tx_ready = 0;
    chk(rx_clear === 1'b1 && tx_valid === 1'b0, "R10 clear after reply", {rx_clear, tx_valid}, 2'b10);
    if (stray) begin
      repeat (600) begin step(); if (tx_valid) seen = 1; end
      chk(!seen, "R10 no second reply", seen, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) step();
    chk(tx_valid === 1'b0 && rx_clear === 1'b0, "R11 reset", {tx_valid, rx_clear}, 0);
    rst_n = 1;
    step();
    chk(tx_valid === 1'b0 && rx_clear === 1'b0, "R11 after reset", {tx_valid, rx_clear}, 0);
    frame(8'd6, 8'h00, 8'd0, 1, 10, 100, 0);    // R2
    frame(8'd6, 8'h00, 8'd1, 1, 0, 100, 0);     // R3
    frame(8'd16, 8'h06, 8'd0, 1, 100, 100, 0);  // R4
    frame(8'd6, 8'h06, 8'd9, 1, 5, 100, 0);     // R4 minimum read length
    frame(8'd6, 8'h00, 8'd0, 0, 10, 100, 0);    // R1
    frame(8'd5, 8'h06, 8'd0, 1, 10, 100, 0);    // R5 short read
    frame(8'd7, 8'h00, 8'd0, 1, 10, 100, 0);    // R5 long poll
    frame(8'd6, 8'h00, 8'd2, 1, 10, 100, 0);    // R5 unknown request code
    frame(8'd6, 8'h04, 8'd0, 1, 10, 100, 0);    // R5 other command
    frame(8'd6, 8'h00, 8'd1, 1, 700, 100, 0);   // R8 gap already elapsed
    now_ts = 16'hFF80;
    frame(8'd6, 8'h00, 8'd0, 1, 20, 100, 0);    // R8 across wrap
    frame(8'd20, 8'h06, 8'd0, 1, 3, 20, 0);     // R9 heavy back-pressure
    frame(8'd6, 8'h00, 8'd0, 1, 0, 60, 1);      // R10 stray frame while pending
    for (int n = 0; n < 24; n++) begin
      int sel = $urandom() % 6;
      bit [7:0] l = (sel < 2) ? 8'd6 : 8'($urandom() % 12);
      bit [7:0] c = (sel == 5) ? 8'($urandom()) : (sel[0] ? 8'h06 : 8'h00);
      frame(l, c, 8'($urandom() % 3), ($urandom() % 8) != 0,
            int'($urandom() % 800), 30 + int'($urandom() % 71), 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule